// File: doc/BRIEF.md
# Pixel Rectangle Transfer Engine

The engine moves pixel data between a 32-bit host data port and a frame store of 1024 columns by 512 rows of 16-bit pixels. The store sits outside the block behind a simple synchronous single-port RAM interface with one cycle of read latency. A transfer is started with a position word and a size word. The engine then walks the rectangle row by row, left to right, and splits or packs two pixels per host word.

On writes the host offers words with a valid/ready handshake. Each accepted word becomes two RAM writes. An optional mask-set control forces the top bit of every written pixel. On reads the engine fetches the first pixel pair as soon as the transfer starts and holds each packed word until the host pops it. The host may pause for any number of cycles between words, including in the middle of a row. A busy flag covers the whole transfer, and a one-cycle done pulse marks its end.

Top module: `vram_xfer_engine`

## Requirements
- R1: After reset, busy, done, wr_ready, rd_valid and mem_en are all 0.
- R2: The start column is pos_word[9:0] and the start row is pos_word[24:16]. Bits 15:10 and 31:25 of pos_word have no effect.
- R3: The width is size_word[9:0], with 0 meaning 1024. The height is size_word[24:16], with 0 meaning 512. All other bits of size_word are ignored.
- R4: Pixel i of the rectangle is at RAM address row*1024 + column. Pixels are ordered left to right within a row, then row by row downward. In a host word, bits 15:0 carry the earlier pixel and bits 31:16 the next one.
- R5: Columns wrap modulo 1024 and rows wrap modulo 512 when the rectangle crosses the edge of the store.
- R6: If mask_set is 1 when a write transfer starts, bit 15 of every pixel written by that transfer is 1. Otherwise pixels are written unchanged.
- R7: The host may hold wr_valid low for any number of cycles between words, including mid-row. The pixel sequence continues from the next column without loss.
- R8: When the pixel count is odd, bits 31:16 of the last write word are not written anywhere. On a read, bits 31:16 of the last word are 0.
- R9: A read transfer presents its first word (rd_valid = 1) without any rd_pop from the host.
- R10: busy rises on the clock edge that accepts start. It falls on the edge after the last pixel is written, or after the last read word is popped. done is 1 for exactly the first cycle in which busy is 0 again.
- R11: A start pulse while busy is 1 is ignored.
- R12: rd_data stays stable while rd_valid is 1 and rd_pop is 0. A pop advances to the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| dir_read | input | 1 | 1 = store to host, 0 = host to store |
| pos_word | input | 32 | Start position word |
| size_word | input | 32 | Rectangle size word |
| mask_set | input | 1 | Force bit 15 on written pixels |
| wr_valid | input | 1 | Host write word valid |
| wr_data | input | 32 | Host write word, two pixels |
| wr_ready | output | 1 | Engine accepts a write word |
| rd_pop | input | 1 | Host consumes the current read word |
| rd_valid | output | 1 | Read word available |
| rd_data | output | 32 | Read word, two pixels |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 19 | RAM pixel address |
| mem_wdata | output | 16 | RAM write pixel |
| mem_rdata | input | 16 | RAM read pixel, one cycle after the request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The in-line properties check, on every cycle, the local rules that must always hold:
- done lasts one cycle and coincides with busy falling.
- RAM and handshake activity occur only while busy.
- Masked writes carry bit 15.
- The read word holds still until popped.
- The cursor never steps past the end of the rectangle or outside its width.

The bench scenarios cover what needs knowledge of the whole transfer:
- the decode of the position and size fields, including the zero-means-full cases;
- the pixel-to-address order with wrap at both edges;
- resumption after host pauses;
- handling of odd counts;
- the prefetch of the first read word;
- rejection of a second start.

// File: rtl/vxe_pkg.sv
package vxe_pkg;

    localparam int XW     = 10;          // column address bits
    localparam int YW     = 9;           // row address bits
    localparam int AW     = XW + YW;     // pixel address bits
    localparam int PW     = 16;          // pixel width
    localparam int WW     = 2 * PW;      // host word width
    localparam int Y_LSB  = 16;          // row field position in both words

    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        logic [XW:0]   w;
        logic [YW:0]   h;
    } rect_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_WAIT,
        ST_WR_LO,
        ST_WR_HI,
        ST_RD_LO,
        ST_RD_HI,
        ST_RD_END,
        ST_RD_HAVE
    } xfer_state_t;

    // Field value zero stands for the full extent: prepend the zero flag.
    function automatic rect_t decode_rect(input logic [WW-1:0] pos,
                                          input logic [WW-1:0] size);
        rect_t r;
        r.x = pos[XW-1:0];
        r.y = pos[Y_LSB +: YW];
        r.w = {(size[XW-1:0] == '0), size[XW-1:0]};
        r.h = {(size[Y_LSB +: YW] == '0), size[Y_LSB +: YW]};
        return r;
    endfunction

    function automatic logic [AW-1:0] pix_addr(input logic [XW-1:0] x,
                                               input logic [YW-1:0] y);
        return {y, x};
    endfunction

    function automatic logic [PW-1:0] apply_mask(input logic [PW-1:0] p,
                                                 input logic m);
        return {p[PW-1] | m, p[PW-2:0]};
    endfunction

endpackage

// File: rtl/vxe_cursor.sv
module vxe_cursor
    import vxe_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  rect_t         rect_in,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last,
    output logic          spent
);

    rect_t         rect_q;
    logic [XW-1:0] col_q;
    logic [YW-1:0] row_q;
    logic          spent_q;
    logic [XW-1:0] cur_x;
    logic [YW-1:0] cur_y;
    logic          row_end;

    always_comb begin
        cur_x   = rect_q.x + col_q;          // truncation wraps modulo 1024
        cur_y   = rect_q.y + row_q;          // truncation wraps modulo 512
        row_end = ({1'b0, col_q} == rect_q.w - 1'b1);
        last    = row_end && ({1'b0, row_q} == rect_q.h - 1'b1);
    end

    assign addr  = pix_addr(cur_x, cur_y);
    assign spent = spent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rect_q  <= '0;
            col_q   <= '0;
            row_q   <= '0;
            spent_q <= 1'b0;
        end else if (load) begin
            rect_q  <= rect_in;
            col_q   <= '0;
            row_q   <= '0;
            spent_q <= 1'b0;
        end else if (step && !spent_q) begin
            if (row_end) begin
                col_q <= '0;
                row_q <= row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
            if (last)
                spent_q <= 1'b1;
        end
    end

    // R4: the column offset stays inside the loaded width
    p_col_in_rect_r4: assert property (@(posedge clk) disable iff (rst)
        (rect_q.w != '0) |-> ({1'b0, col_q} < rect_q.w));

    // R10: the sequencer never steps a cursor that has finished
    p_no_step_after_end_r10: assert property (@(posedge clk) disable iff (rst)
        step |-> !spent_q);

endmodule

// File: rtl/vxe_rd_pack.sv
module vxe_rd_pack
    import vxe_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_lo,
    input  logic          cap_hi,
    input  logic          zero_hi,
    input  logic [PW-1:0] din,
    output logic [WW-1:0] pair
);

    logic [PW-1:0] lo_q;
    logic [PW-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo)
                lo_q <= din;
            if (cap_hi)
                hi_q <= din;
            else if (zero_hi)
                hi_q <= '0;
        end
    end

    assign pair = {hi_q, lo_q};

    // R8: the upper half is cleared only when it is not also captured
    p_zero_excl_r8: assert property (@(posedge clk) disable iff (rst)
        zero_hi |-> !cap_hi);

endmodule

// File: rtl/vram_xfer_engine.sv
module vram_xfer_engine
    import vxe_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          dir_read,
    input  logic [31:0]   pos_word,
    input  logic [31:0]   size_word,
    input  logic          mask_set,
    input  logic          wr_valid,
    input  logic [31:0]   wr_data,
    output logic          wr_ready,
    input  logic          rd_pop,
    output logic          rd_valid,
    output logic [31:0]   rd_data,
    output logic          mem_en,
    output logic          mem_we,
    output logic [18:0]   mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          busy,
    output logic          done
);

    xfer_state_t   state_q, state_d;
    logic [WW-1:0] word_q;
    logic          mask_q;
    logic          odd_q, odd_d;
    logic          done_q;
    logic          load, step, fin;
    logic          cap_lo, cap_hi, zero_hi;
    logic [AW-1:0] cur_addr;
    logic          cur_last, cur_spent;
    rect_t         rect_new;

    assign rect_new = decode_rect(pos_word, size_word);

    vxe_cursor u_cursor (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .rect_in (rect_new),
        .step    (step),
        .addr    (cur_addr),
        .last    (cur_last),
        .spent   (cur_spent)
    );

    vxe_rd_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .cap_lo  (cap_lo),
        .cap_hi  (cap_hi),
        .zero_hi (zero_hi),
        .din     (mem_rdata),
        .pair    (rd_data)
    );

    always_comb begin
        state_d   = state_q;
        odd_d     = odd_q;
        load      = 1'b0;
        step      = 1'b0;
        fin       = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        wr_ready  = 1'b0;
        cap_lo    = 1'b0;
        cap_hi    = 1'b0;
        zero_hi   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = dir_read ? ST_RD_LO : ST_WR_WAIT;
                end
            end
            ST_WR_WAIT: begin
                wr_ready = 1'b1;
                if (wr_valid)
                    state_d = ST_WR_LO;
            end
            ST_WR_LO: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = apply_mask(word_q[PW-1:0], mask_q);
                step      = 1'b1;
                if (cur_last) begin
                    fin     = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_WR_HI;
                end
            end
            ST_WR_HI: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = apply_mask(word_q[WW-1:PW], mask_q);
                step      = 1'b1;
                if (cur_last) begin
                    fin     = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_WR_WAIT;
                end
            end
            ST_RD_LO: begin
                mem_en  = 1'b1;
                step    = 1'b1;
                odd_d   = cur_last;
                state_d = cur_last ? ST_RD_END : ST_RD_HI;
            end
            ST_RD_HI: begin
                cap_lo  = 1'b1;
                mem_en  = 1'b1;
                step    = 1'b1;
                state_d = ST_RD_END;
            end
            ST_RD_END: begin
                if (odd_q) begin
                    cap_lo  = 1'b1;
                    zero_hi = 1'b1;
                end else begin
                    cap_hi  = 1'b1;
                end
                state_d = ST_RD_HAVE;
            end
            ST_RD_HAVE: begin
                if (rd_pop) begin
                    if (cur_spent) begin
                        fin     = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_RD_LO;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            mask_q  <= 1'b0;
            odd_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            odd_q   <= odd_d;
            done_q  <= fin;
            if (load)
                mask_q <= mask_set & ~dir_read;
            if (wr_ready && wr_valid)
                word_q <= wr_data;
        end
    end

    assign mem_addr = cur_addr;
    assign busy     = (state_q != ST_IDLE);
    assign rd_valid = (state_q == ST_RD_HAVE);
    assign done     = done_q;

    // R10: completion is a single-cycle pulse
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: busy only falls together with the completion pulse
    p_busy_fall_done_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(busy)) |-> done);

    // R7: write handshake is offered only during a transfer
    p_ready_busy_r7: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> busy);

    // R1: no RAM traffic while idle
    p_mem_idle_r1: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> busy);

    // R6: masked writes always carry the top bit
    p_mask_bit_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mask_q) |-> mem_wdata[PW-1]);

    // R12: the presented read word holds until popped
    p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_pop) |=> (rd_valid && $stable(rd_data)));

    // R11: a start seen while busy does not restart the cursor
    p_start_busy_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !load);

endmodule

// File: tb/vram_xfer_engine_tb.sv
`timescale 1ns/1ps
module vram_xfer_engine_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, dir_read, mask_set;
    logic [31:0] pos_word, size_word;
    logic        wr_valid;
    logic [31:0] wr_data;
    logic        wr_ready;
    logic        rd_pop;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        mem_en, mem_we;
    logic [18:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        busy, done;

    int n_checks = 0;
    int n_fail   = 0;
    int done_cnt = 0;

    logic [15:0] mem [int];

    always #2 clk = ~clk;

    vram_xfer_engine u_dut (
        .clk(clk), .rst(rst), .start(start), .dir_read(dir_read),
        .pos_word(pos_word), .size_word(size_word), .mask_set(mask_set),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_pop(rd_pop), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done)
    );

    // Synchronous single-port RAM model, one cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we)
                mem[int'(mem_addr)] = mem_wdata;
            else
                mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0;
        end
    end

    always @(negedge clk) if (done) done_cnt++;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int pa(int x0, int y0, int w, int i);
        int x = (x0 + i % w) % 1024;
        int y = (y0 + i / w) % 512;
        return y * 1024 + x;
    endfunction

    function automatic logic [15:0] pix(int seed, int i);
        return 16'((seed * 977 + i * 13 + 7) & 16'h7FFF);
    endfunction

    function automatic int dec_w(logic [31:0] s);
        return (s[9:0] == 0) ? 1024 : int'(s[9:0]);
    endfunction

    function automatic int dec_h(logic [31:0] s);
        return (s[24:16] == 0) ? 512 : int'(s[24:16]);
    endfunction

    task automatic pulse_start(input logic [31:0] pos, input logic [31:0] size,
                               input bit rd, input bit msk);
        @(negedge clk);
        start = 1'b1; dir_read = rd; pos_word = pos; size_word = size; mask_set = msk;
        @(negedge clk);
        start = 1'b0; mask_set = 1'b0;
    endtask

    task automatic wait_idle_and_done(input int d0, input string req);
        while (busy) @(negedge clk);
        @(negedge clk);
        check(done_cnt == d0 + 1, req, "done pulses", done_cnt - d0, 1);
    endtask

    // Write scenario: data, mask, pauses, wrap and odd handling per arguments
    task automatic do_write(input logic [31:0] pos, input logic [31:0] size,
                            input bit msk, input int gap, input int seed,
                            input string req);
        int x0 = int'(pos[9:0]);
        int y0 = int'(pos[24:16]);
        int w = dec_w(size);
        int h = dec_h(size);
        int total = w * h;
        int nwords = (total + 1) / 2;
        int d0 = done_cnt;
        int bad = 0;
        int first_a = 0;
        logic [15:0] first_act = '0, first_exp = '0;
        pulse_start(pos, size, 1'b0, msk);
        check(busy == 1'b1, "R10", "busy after start", busy, 1);
        for (int k = 0; k < nwords; k++) begin
            logic [15:0] lo = pix(seed, 2 * k);
            logic [15:0] hi = (2 * k + 1 < total) ? pix(seed, 2 * k + 1) : 16'hBEEF;
            while (!wr_ready) @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = {hi, lo};
            @(negedge clk);
            wr_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
        wait_idle_and_done(d0, "R10");
        for (int i = 0; i < total; i++) begin
            int a = pa(x0, y0, w, i);
            logic [15:0] e = pix(seed, i) | (msk ? 16'h8000 : 16'h0);
            logic [15:0] v = mem.exists(a) ? mem[a] : 16'h0;
            if (v !== e) begin
                if (bad == 0) begin first_a = a; first_act = v; first_exp = e; end
                bad++;
            end
        end
        check(bad == 0, req, $sformatf("pixel data at %0h", first_a), first_act, first_exp);
    endtask

    // Read scenario: preload, prefetch, word packing, odd tail
    task automatic do_read(input logic [31:0] pos, input logic [31:0] size,
                           input int seed, input string req);
        int x0 = int'(pos[9:0]);
        int y0 = int'(pos[24:16]);
        int w = dec_w(size);
        int h = dec_h(size);
        int total = w * h;
        int nwords = (total + 1) / 2;
        int d0 = done_cnt;
        int bad = 0;
        int waited = 0;
        logic [31:0] fa = '0, fe = '0;
        for (int i = 0; i < total; i++) mem[pa(x0, y0, w, i)] = pix(seed, i) | 16'h8000;
        pulse_start(pos, size, 1'b1, 1'b0);
        while (!rd_valid && waited < 8) begin @(negedge clk); waited++; end
        check(rd_valid == 1'b1, "R9", "prefetch without pop", rd_valid, 1);
        for (int k = 0; k < nwords; k++) begin
            logic [31:0] e;
            e[15:0]  = pix(seed, 2 * k) | 16'h8000;
            e[31:16] = (2 * k + 1 < total) ? (pix(seed, 2 * k + 1) | 16'h8000) : 16'h0;
            while (!rd_valid) @(negedge clk);
            if (rd_data !== e) begin
                if (bad == 0) begin fa = rd_data; fe = e; end
                bad++;
            end
            rd_pop = 1'b1;
            @(negedge clk);
            rd_pop = 1'b0;
        end
        check(bad == 0, req, "read words", fa, fe);
        wait_idle_and_done(d0, "R10");
    endtask

    task automatic t_reset();
        check(busy == 0 && done == 0 && wr_ready == 0 && rd_valid == 0 && mem_en == 0,
              "R1", "idle outputs after reset",
              {busy, done, wr_ready, rd_valid, mem_en}, 0);
    endtask

    task automatic t_odd_write();
        // 3x1 at (40,20): the pixel after the end must stay untouched (R8)
        mem[20 * 1024 + 43] = 16'h1234;
        do_write(32'h0014_0028, 32'h0001_0003, 1'b0, 0, 3, "R4");
        check(mem[20 * 1024 + 43] == 16'h1234, "R8", "neighbour after odd tail",
              mem[20 * 1024 + 43], 16'h1234);
    endtask

    task automatic t_start_busy();
        int d0 = done_cnt;
        pulse_start(32'h0064_0064, 32'h0001_0002, 1'b0, 1'b0);
        pulse_start(32'h00C8_00C8, 32'h0001_0002, 1'b1, 1'b0);
        check(wr_ready == 1'b1, "R11", "still in write after second start", wr_ready, 1);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1; wr_data = 32'h2222_1111;
        @(negedge clk);
        wr_valid = 1'b0;
        wait_idle_and_done(d0, "R11");
        check(mem[100 * 1024 + 100] == 16'h1111 && mem[100 * 1024 + 101] == 16'h2222,
              "R11", "first transfer completed", mem[100 * 1024 + 101], 16'h2222);
        check(!mem.exists(200 * 1024 + 200), "R11", "second start had no access", 1, 0);
    endtask

    task automatic t_read_hold();
        // rd_data must not move while not popped (R12)
        logic [31:0] snap;
        mem[7 * 1024 + 9] = 16'hAAAA;
        mem[7 * 1024 + 10] = 16'h5555;
        pulse_start(32'h0007_0009, 32'h0001_0002, 1'b1, 1'b0);
        while (!rd_valid) @(negedge clk);
        snap = rd_data;
        repeat (5) @(negedge clk);
        check(rd_valid && rd_data == snap && snap == 32'h5555_AAAA, "R12",
              "word held without pop", rd_data, 32'h5555_AAAA);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R12", "pop of last word ends transfer", busy, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; dir_read = 1'b0; mask_set = 1'b0;
        pos_word = '0; size_word = '0; wr_valid = 1'b0; wr_data = '0; rd_pop = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        // R4 plain 3x2 block
        do_write(32'h0005_000A, 32'h0002_0003, 1'b0, 0, 1, "R4");
        // R6 mask set
        do_write(32'h0030_0030, 32'h0002_0004, 1'b1, 0, 2, "R6");
        t_odd_write();
        // R5 + R7 wrap on both edges with pauses mid-row
        do_write(32'h01FF_03FE, 32'h0002_0003, 1'b0, 3, 4, "R5");
        do_write(32'h0001_0101, 32'h0003_0005, 1'b0, 5, 5, "R7");
        // R2 + R3 junk bits in position and size words
        do_write(32'hFA05_FC0A, 32'hFE02_FC03, 1'b0, 1, 6, "R2");
        // R3 width field 0 -> 1024 columns, height field 0 -> 512 rows
        do_write(32'h0007_0005, 32'h0001_0000, 1'b0, 0, 7, "R3");
        do_write(32'h0064_0003, 32'h0000_0001, 1'b0, 0, 8, "R3");
        // Reads: odd tail, wrap, prefetch
        do_read(32'h0021_0011, 32'h0001_0003, 9, "R8");
        do_read(32'h01FF_03FF, 32'h0002_0002, 10, "R5");
        t_read_hold();
        t_start_busy();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule